// File: doc/BRIEF.md
# Expansion Memory Bank Select Decoder

This block sits on the host side of an expansion memory board that carries one read-only EPROM bank and one battery-backed SRAM bank. Software picks a bank by issuing an I/O write to a fixed port. The block holds the value written and compares it with bank numbers set by jumpers. From the comparison results it drives chip selects and enables for both memories whenever the CPU touches the top 16K of its address space.

The comparison is not the same for both memories. The EPROM needs a full 8-bit match. SRAM reads and SRAM writes each compare only the low nibble, against their own jumper values. Reads from the board need the host's upper-ROM enable. Writes to the SRAM do not need it. The block never inhibits the host's internal RAM, so each SRAM write also lands in that RAM. While the board answers a read, the block asserts a claim output that keeps the internal upper ROM off the data bus.

All outputs are combinational from the held bank number and the live bus strobes. The only state is the bank register, which sits behind a reset synchronizer.

Top module: `xmb_decode`

## Requirements
- R1: After reset the held bank number is 00h, so a board read selects the EPROM when its jumper value is 00h.
- R2: On a clock edge where IORQ and WR are both low, M1 is high and address bits [15:8] equal DFh, the data bus value is stored as the bank number. Address bits [7:0] are ignored. An I/O write to any other upper byte leaves the bank number unchanged.
- R3: An I/O cycle with M1 low, such as an interrupt acknowledge, never changes the bank number.
- R4: `rom_cs_n` is low only during a qualified board read in which all 8 bank bits equal `jmp_rom_id`.
- R5: During a qualified board read, the SRAM is selected (`sram_cs_n` low, `sram_we_n` high) when bank bits [3:0] equal `jmp_sram_rd_id`. Bank bits [7:4] are don't-care.
- R6: During a memory write (MREQ and WR low) in the window, `sram_cs_n` and `sram_we_n` go low when bank bits [3:0] equal `jmp_sram_wr_id`, whatever the level of `upper_rom_en`.
- R7: No select, enable or claim output is active unless address bits 15 and 14 are both high.
- R8: Reads (MREQ and RD low) select neither memory and leave `mem_oe_n` high while `upper_rom_en` is low.
- R9: When a read matches both the EPROM and the SRAM read value, only the EPROM is selected.
- R10: `rom_dis` is high exactly while `mem_oe_n` is low, which is only during a qualified board read. It is never high for a write.
- R11: The outputs follow the bus strobes with no clock delay. A select drops in the same cycle its strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address bus |
| data | input | 8 | CPU data bus, as seen on writes |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge, active low |
| upper_rom_en | input | 1 | Host enables upper ROM reads |
| jmp_rom_id | input | 8 | Jumper bank number for the EPROM |
| jmp_sram_rd_id | input | 4 | Jumper nibble for SRAM reads |
| jmp_sram_wr_id | input | 4 | Jumper nibble for SRAM writes |
| rom_cs_n | output | 1 | EPROM chip select, active low |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| mem_oe_n | output | 1 | Output enable for whichever memory is read, active low |
| rom_dis | output | 1 | Claims the bus from the internal upper ROM |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit bank number, a 4-bit SRAM compare and port DFh. These are the widths at which nibble aliasing can occur. At those widths the bench can choose EPROM and SRAM jumper values that share a low nibble, and bank numbers that differ from a jumper only in bits [7:4]. That brings the priority case and the don't-care upper bits into reach in both random and directed cycles. The two-stage reset synchronizer at its default depth keeps the first usable bank write within a few cycles of reset release.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

  // Bus cycle classes derived from the strobes
  typedef struct packed {
    logic io_wr;   // qualified I/O write (M1 inactive)
    logic mem_rd;  // memory read strobe pair
    logic mem_wr;  // memory write strobe pair
    logic in_win;  // address lies in the top window
  } bus_req_t;

  // Which memory sources the read data
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_ROM  = 2'b01,
    SRC_SRAM = 2'b10
  } rd_src_e;

endpackage

// File: rtl/xmb_rst_sync.sv
module xmb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/xmb_bus_qual.sv
module xmb_bus_qual
  import xmb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_ID = 8'hDF,
  parameter int unsigned WIN_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  output bus_req_t          req
);

  logic [PORT_W-1:0] port_hi;
  logic              port_hit;
  logic [WIN_W-1:0]  win_bits;

  always_comb begin
    port_hi    = addr[ADDR_W-1 -: PORT_W];
    port_hit   = (port_hi == PORT_ID);
    win_bits   = addr[ADDR_W-1 -: WIN_W];
    req.in_win = &win_bits;
    req.io_wr  = !iorq_n && !wr_n && m1_n && port_hit;
    req.mem_rd = !mreq_n && !rd_n;
    req.mem_wr = !mreq_n && !wr_n;
  end

endmodule

// File: rtl/xmb_bank_reg.sv
module xmb_bank_reg #(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_q
);

  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= bank_d;
  end

  // R2: a qualified port write stores the bus value
  p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bank_q == $past(data_i)));

  // R2: without a port write the bank number holds
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank_q));

endmodule

// File: rtl/xmb_id_match.sv
module xmb_id_match #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);

  logic [W-1:0] eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign eq[i] = ~(a[i] ^ b[i]);
  end

  assign hit = &eq;

endmodule

// File: rtl/xmb_sel_logic.sv
module xmb_sel_logic
  import xmb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_req_t req,
  input  logic     upper_rom_en,
  input  logic     rom_hit,
  input  logic     srd_hit,
  input  logic     swr_hit,
  output logic     rom_cs_n,
  output logic     sram_cs_n,
  output logic     sram_we_n,
  output logic     mem_oe_n,
  output logic     rom_dis
);

  rd_src_e src;
  logic    rd_ok;
  logic    wr_ok;

  always_comb begin
    rd_ok = req.mem_rd && req.in_win && upper_rom_en;
    wr_ok = req.mem_wr && req.in_win && swr_hit;
    if (!rd_ok)       src = SRC_NONE;
    else if (rom_hit) src = SRC_ROM;
    else if (srd_hit) src = SRC_SRAM;
    else              src = SRC_NONE;

    rom_cs_n  = (src != SRC_ROM);
    sram_cs_n = !((src == SRC_SRAM) || wr_ok);
    sram_we_n = !wr_ok;
    mem_oe_n  = (src == SRC_NONE);
    rom_dis   = (src != SRC_NONE);
  end

  // R9: never two memories on the data bus
  p_one_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !sram_cs_n));

  // R10: claim only accompanies an enabled read
  p_claim_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_dis |-> (!mem_oe_n && sram_we_n));

endmodule

// File: rtl/xmb_decode.sv
module xmb_decode
  import xmb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned BANK_W      = 8,
  parameter int unsigned SRAM_ID_W   = 4,
  parameter logic [7:0]  PORT_ID     = 8'hDF,
  parameter int unsigned WIN_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BANK_W-1:0]    data,
  input  logic                 iorq_n,
  input  logic                 mreq_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic                 m1_n,
  input  logic                 upper_rom_en,
  input  logic [BANK_W-1:0]    jmp_rom_id,
  input  logic [SRAM_ID_W-1:0] jmp_sram_rd_id,
  input  logic [SRAM_ID_W-1:0] jmp_sram_wr_id,
  output logic                 rom_cs_n,
  output logic                 sram_cs_n,
  output logic                 sram_we_n,
  output logic                 mem_oe_n,
  output logic                 rom_dis
);

  localparam int unsigned PORT_W = ADDR_W / 2;

  logic              rst_n_s;
  bus_req_t          req;
  logic [BANK_W-1:0] bank_q;
  logic              rom_hit;
  logic              srd_hit;
  logic              swr_hit;

  xmb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  xmb_bus_qual #(
    .ADDR_W (ADDR_W),
    .PORT_W (PORT_W),
    .PORT_ID(PORT_ID[PORT_W-1:0]),
    .WIN_W  (WIN_W)
  ) u_qual (
    .addr  (addr),
    .iorq_n(iorq_n),
    .mreq_n(mreq_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .m1_n  (m1_n),
    .req   (req)
  );

  xmb_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (req.io_wr),
    .data_i(data),
    .bank_q(bank_q)
  );

  xmb_id_match #(.W(BANK_W)) u_rom_match (
    .a  (bank_q),
    .b  (jmp_rom_id),
    .hit(rom_hit)
  );

  xmb_id_match #(.W(SRAM_ID_W)) u_srd_match (
    .a  (bank_q[SRAM_ID_W-1:0]),
    .b  (jmp_sram_rd_id),
    .hit(srd_hit)
  );

  xmb_id_match #(.W(SRAM_ID_W)) u_swr_match (
    .a  (bank_q[SRAM_ID_W-1:0]),
    .b  (jmp_sram_wr_id),
    .hit(swr_hit)
  );

  xmb_sel_logic u_sel (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .req         (req),
    .upper_rom_en(upper_rom_en),
    .rom_hit     (rom_hit),
    .srd_hit     (srd_hit),
    .swr_hit     (swr_hit),
    .rom_cs_n    (rom_cs_n),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .mem_oe_n    (mem_oe_n),
    .rom_dis     (rom_dis)
  );

  // R3: an M1 I/O cycle leaves the bank untouched
  p_m1_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!m1_n && !iorq_n) |=> $stable(bank_q));

  // R7: nothing is active outside the top window
  p_window_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(addr[ADDR_W-1] && addr[ADDR_W-2]) |-> (rom_cs_n && sram_cs_n && mem_oe_n && !rom_dis));

  // R8: reads need the upper-ROM enable
  p_read_gate_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !upper_rom_en |-> (mem_oe_n && rom_cs_n && !rom_dis));

  // R6: a write enable only appears with both write strobes
  p_write_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sram_we_n |-> (!mreq_n && !wr_n && !sram_cs_n));

endmodule

// File: tb/xmb_decode_bench.sv
`timescale 1ns/1ps
module xmb_decode_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  data;
  logic        iorq_n, mreq_n, rd_n, wr_n, m1_n, upper_rom_en;
  logic [7:0]  jmp_rom_id;
  logic [3:0]  jmp_sram_rd_id, jmp_sram_wr_id;
  logic        rom_cs_n, sram_cs_n, sram_we_n, mem_oe_n, rom_dis;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m_bank;
  bit summary_done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  xmb_decode u_xmb_decode (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data),
    .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .upper_rom_en(upper_rom_en), .jmp_rom_id(jmp_rom_id),
    .jmp_sram_rd_id(jmp_sram_rd_id), .jmp_sram_wr_id(jmp_sram_wr_id),
    .rom_cs_n(rom_cs_n), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
    .mem_oe_n(mem_oe_n), .rom_dis(rom_dis)
  );

  // Expected {rom_cs_n, sram_cs_n, sram_we_n, mem_oe_n, rom_dis}
  function automatic logic [4:0] expect_outs(logic [7:0] bank);
    bit win, rd, wr, rom, srd, swr;
    win = addr[15] && addr[14];
    rd  = !mreq_n && !rd_n && win && upper_rom_en;
    wr  = !mreq_n && !wr_n && win;
    rom = rd && (bank == jmp_rom_id);
    srd = rd && !rom && (bank[3:0] == jmp_sram_rd_id);
    swr = wr && (bank[3:0] == jmp_sram_wr_id);
    return {!rom, !(srd || swr), !swr, !(rom || srd), rom || srd};
  endfunction

  function automatic bit loads_bank();
    return !iorq_n && !wr_n && m1_n && (addr[15:8] == 8'hDF);
  endfunction

  task automatic check1(string tag, logic act, logic exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b addr=%h bank=%h", tag, what, act, exp, addr, m_bank);
    end
  endtask

  task automatic check_all(string tag);
    logic [4:0] e;
    e = expect_outs(m_bank);
    check1(tag, rom_cs_n,  e[4], "rom_cs_n");
    check1(tag, sram_cs_n, e[3], "sram_cs_n");
    check1(tag, sram_we_n, e[2], "sram_we_n");
    check1(tag, mem_oe_n,  e[1], "mem_oe_n");
    check1(tag, rom_dis,   e[0], "rom_dis");
  endtask

  task automatic idle();
    iorq_n = 1; mreq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1;
  endtask

  // Drive at negedge, check mid-cycle, advance model at posedge
  task automatic step(string tag);
    #1 check_all(tag);
    @(posedge clk);
    if (loads_bank()) m_bank = data;
    @(negedge clk);
  endtask

  task automatic io_wr(logic [15:0] a, logic [7:0] d, logic m1, string tag);
    idle(); addr = a; data = d; iorq_n = 0; wr_n = 0; m1_n = m1;
    step(tag);
  endtask

  task automatic mem_rd(logic [15:0] a, string tag);
    idle(); addr = a; mreq_n = 0; rd_n = 0;
    step(tag);
  endtask

  task automatic mem_wr(logic [15:0] a, string tag);
    idle(); addr = a; data = 8'h00; mreq_n = 0; wr_n = 0;
    step(tag);
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; idle(); addr = 16'h0000; data = 8'h00; upper_rom_en = 1;
    jmp_rom_id = 8'h00; jmp_sram_rd_id = 4'h3; jmp_sram_wr_id = 4'h7;
    m_bank = 8'h00;
    repeat (3) @(negedge clk);
    mem_rd(16'hC123, "R1");  // reset state, async reset held
    rst_n = 1;
    repeat (4) mem_rd(16'hFFFF, "R1");

    // R2: port write with arbitrary low byte
    io_wr(16'hDF37, 8'h5A, 1'b1, "R2");
    jmp_rom_id = 8'h5A;
    mem_rd(16'hC000, "R2");
    check1("R2", rom_cs_n, 1'b0, "rom_cs_n after load");
    // R2: other port ignored
    io_wr(16'hDE00, 8'h11, 1'b1, "R2");
    mem_rd(16'hE000, "R2");
    check1("R2", rom_cs_n, 1'b0, "rom_cs_n after wrong port");

    // R3: M1 cycle ignored
    io_wr(16'hDF00, 8'h22, 1'b0, "R3");
    mem_rd(16'hD000, "R3");
    check1("R3", rom_cs_n, 1'b0, "rom_cs_n after M1 cycle");

    // R4/R5: upper bits differ, nibble matches SRAM read
    jmp_rom_id = 8'hA3; jmp_sram_rd_id = 4'h3;
    io_wr(16'hDF01, 8'h53, 1'b1, "R4");
    mem_rd(16'hC800, "R5");
    check1("R4", rom_cs_n, 1'b1, "rom_cs_n partial match");
    check1("R5", sram_cs_n, 1'b0, "sram_cs_n nibble match");

    // R9: both match -> EPROM only
    jmp_rom_id = 8'h53;
    mem_rd(16'hF000, "R9");
    check1("R9", sram_cs_n, 1'b1, "sram_cs_n on priority");

    // R7: address just below the window
    mem_rd(16'hBFFF, "R7");
    check1("R7", rom_cs_n, 1'b1, "rom_cs_n outside window");

    // R8 and R6: reads gated, writes not
    upper_rom_en = 0; jmp_sram_wr_id = 4'h3;
    mem_rd(16'hC000, "R8");
    check1("R8", mem_oe_n, 1'b1, "mem_oe_n without enable");
    mem_wr(16'hC000, "R6");
    check1("R6", sram_we_n, 1'b0, "sram_we_n without enable");
    check1("R10", rom_dis, 1'b0, "rom_dis on write");
    upper_rom_en = 1;

    // R11: strobe release mid-cycle, no clock edge in between
    idle(); addr = 16'hC000; mreq_n = 0; rd_n = 0;
    #1 check1("R11", rom_cs_n, 1'b0, "rom_cs_n asserted");
    rd_n = 1; mreq_n = 1;
    #1 check1("R11", rom_cs_n, 1'b1, "rom_cs_n released");
    check1("R11", rom_dis, 1'b1 ^ 1'b1, "rom_dis released");
    @(negedge clk);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int kind;
      if (i % 150 == 0) begin
        jmp_rom_id     = 8'($urandom);
        jmp_sram_rd_id = ($urandom % 3 == 0) ? jmp_rom_id[3:0] : 4'($urandom);
        jmp_sram_wr_id = ($urandom % 2 == 0) ? jmp_sram_rd_id : 4'($urandom);
      end
      upper_rom_en = ($urandom % 4 != 0);
      kind = int'($urandom % 8);
      idle();
      addr = 16'($urandom);
      if ($urandom % 4 != 0) addr[15:14] = 2'b11;
      data = 8'($urandom);
      case (kind)
        0, 1: begin
          if ($urandom % 4 != 0) addr[15:8] = 8'hDF;
          case ($urandom % 4)
            0: data = jmp_rom_id;
            1: data = {4'($urandom), jmp_sram_rd_id};
            2: data = {4'($urandom), jmp_sram_wr_id};
            default: ;
          endcase
          iorq_n = 0; wr_n = 0; m1_n = ($urandom % 6 != 0);
        end
        2, 3, 4: begin mreq_n = 0; rd_n = 0; end
        5, 6:    begin mreq_n = 0; wr_n = 0; end
        default: ;
      endcase
      step((kind >= 5) ? "R6" : "R4");
    end

    finish_run();
  end

endmodule